// File: doc/BRIEF.md
# Dual-Mode Multiplexed Processor Bus Slave

This block connects an 8-bit multiplexed address/data processor bus to a bank of 256 byte-wide registers that live outside it. An address-latch strobe captures the register address from the shared lines. A chip-select window then frames one read or one write. A strap input picks how the two strobe pins are read. In split mode, one pin is an active-low read strobe and the other is an active-low write strobe. In strobe/direction mode, the first pin is an active-low data strobe and the second pin gives the direction (high for read, low for write).

All bus inputs pass through two-flop synchronisers into the block clock before any edge is detected, so the bus may be fully asynchronous. Toward the register bank the block presents a plain port: address, write data, a one-cycle write enable, a one-cycle read enable, and a read data input. The register port has no back-pressure. The bank must accept a write in the cycle the enable is high and must return read data combinationally in the cycle the read enable is high. The shared bus is modelled as a data input, a data output and an output enable.

Top module: `muxbus_regport`

## Requirements
- R1: In split mode (`bus_mode`=0), a low `rd_n` while `cs_n` is low gives one `reg_re` pulse at the latched address. The bus then drives that register's value with `bus_oe` high.
- R2: In split mode, a low `wr_n` while `cs_n` is low writes the data on `bus_din` into the latched address.
- R3: In strobe/direction mode (`bus_mode`=1), a low `rd_n` with `wr_n` high is a read, and it behaves as in R1.
- R4: In strobe/direction mode, a low `rd_n` with `wr_n` low is a write, and it behaves as in R2.
- R5: The address is captured from `bus_din` when `ale` falls. Later activity on `bus_din` while `ale` is low does not change it.
- R6: While `cs_n` is high, the strobes have no effect: no `reg_we`, no `reg_re` and no `bus_oe`.
- R7: `bus_oe` falls within 4 clock cycles after `cs_n` rises, even if the read strobe is still low.
- R8: Each write cycle gives exactly one `reg_we` pulse. The pulse comes at the end of the write condition, which is the strobe rise or the `cs_n` rise, whichever comes first.
- R9: Out of reset, `bus_oe`, `reg_we` and `reg_re` are 0 and `reg_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | Strap: 0 = split strobes, 1 = strobe plus direction |
| ale | input | 1 | Address latch enable, active high, captures on its fall |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1) |
| wr_n | input | 1 | Write strobe (mode 0) or direction, high = read (mode 1) |
| bus_din | input | 8 | Shared bus, inbound |
| bus_dout | output | 8 | Shared bus, outbound read data |
| bus_oe | output | 1 | Drive enable for the shared bus |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write enable |
| reg_re | output | 1 | One-cycle read enable |
| reg_rdata | input | 8 | Register read data, valid in the `reg_re` cycle |

## Verification
The bench goes after the following corner cases:

- **Chip select rising before the strobe in a write.** A design that commits only on the strobe would drop that write. One that commits on both edges would write twice, and a pulse counter catches both.
- **Read held with the strobe still low after chip select rises.** A design that gates the drive enable on the strobe alone would keep the bus driven.
- **Bus changing after the address-latch fall.** A transparent address latch would send the data byte to the register bank as the address.
- **Strobes toggled with chip select high, in both bus modes.** A design missing the chip-select gate would corrupt a register or drive the bus.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic {
    BUS_SPLIT = 1'b0,
    BUS_DSDIR = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_req_t;
endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/muxbus_strobe_dec.sv
module muxbus_strobe_dec
  import muxbus_pkg::*;
(
  input  bus_mode_e   mode,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  output strobe_req_t req
);
  always_comb begin
    req = '0;
    if (!cs_n) begin
      unique case (mode)
        BUS_SPLIT: begin
          // read wins if both strobes are low
          req.rd = !rd_n;
          req.wr = !wr_n && rd_n;
        end
        BUS_DSDIR: begin
          req.rd = !rd_n && wr_n;
          req.wr = !rd_n && !wr_n;
        end
        default: req = '0;
      endcase
    end
  end
endmodule

// File: rtl/muxbus_cycle.sv
module muxbus_cycle
  import muxbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          cs_n,
  input  logic [DW-1:0] din,
  input  strobe_req_t   req,
  input  logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, dout_q;
  logic ale_d, rd_q, rd_d, wr_q, wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      dout_q <= '0;
      ale_d  <= 1'b0;
      rd_q   <= 1'b0;
      rd_d   <= 1'b0;
      wr_q   <= 1'b0;
      wr_d   <= 1'b0;
    end else begin
      ale_d <= ale;
      if (ale_d && !ale) addr_q <= din[AW-1:0];
      rd_q <= req.rd;
      rd_d <= rd_q;
      wr_q <= req.wr;
      wr_d <= wr_q;
      if (req.wr) wdat_q <= din;
      if (reg_re) dout_q <= reg_rdata;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdat_q;
  assign reg_re    = rd_q && !rd_d;
  assign reg_we    = wr_d && !wr_q;
  assign bus_oe    = rd_q && rd_d;
  assign bus_dout  = dout_q;

  // R8
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R2
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R6
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(!cs_n));

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !bus_oe);

  // R1
  re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
endmodule

// File: rtl/muxbus_regport.sv
module muxbus_regport
  import muxbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CTL_W = 5;
  localparam logic [CTL_W-1:0] CTL_IDLE = 5'b00111;

  logic [CTL_W-1:0] ctl_s;
  logic [DW-1:0]    din_s;
  strobe_req_t      req;
  bus_mode_e        mode_s;

  muxbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .INIT(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_mode, ale, cs_n, rd_n, wr_n}),
    .q(ctl_s)
  );

  muxbus_sync #(.W(DW), .STAGES(SYNC_STAGES), .INIT('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_din), .q(din_s)
  );

  assign mode_s = bus_mode_e'(ctl_s[4]);

  muxbus_strobe_dec u_dec (
    .mode(mode_s), .cs_n(ctl_s[2]), .rd_n(ctl_s[1]), .wr_n(ctl_s[0]), .req(req)
  );

  muxbus_cycle #(.AW(AW), .DW(DW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .ale(ctl_s[3]), .cs_n(ctl_s[2]),
    .din(din_s), .req(req), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );
endmodule

// File: tb/sim_muxbus_regport.sv
module sim_muxbus_regport;
  logic clk = 0, rst_n = 0;
  logic bus_mode = 0, ale = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] bus_din = 0, bus_dout, reg_addr, reg_wdata, reg_rdata;
  logic bus_oe, reg_we, reg_re;
  logic [7:0] bank [256];
  logic [7:0] model [256];
  int checks = 0, failures = 0, we_cnt = 0, re_cnt = 0;

  always #4 clk = ~clk;

  muxbus_regport u0 (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    rd_n = 1;
    wr_n = 1;
  endtask

  task automatic latch_addr(input logic [7:0] a);
    bus_din = a;
    ale = 1;
    tick(4);
    ale = 0;
    tick(4);
  endtask

  // one bus transaction; cs_first ends a write with cs_n rising first
  task automatic bus_op(input bit md, input logic [7:0] a, input bit is_wr,
                        input logic [7:0] d, input bit cs_first, input string tag);
    int w0 = we_cnt;
    bus_mode = md;
    idle_strobes();
    tick(4);
    latch_addr(a);
    bus_din = d;
    cs_n = 0;
    tick(3);
    if (is_wr) begin
      wr_n = 0;
      if (md) begin tick(2); rd_n = 0; end
      tick(6);
      if (cs_first) begin
        cs_n = 1;
        tick(6);
        check({tag, " early-cs commit"}, we_cnt - w0, 1);
        rd_n = 1; tick(2); wr_n = 1;
        tick(6);
      end else begin
        if (md) begin rd_n = 1; tick(2); wr_n = 1; end
        else wr_n = 1;
        tick(6);
        check({tag, " single commit"}, we_cnt - w0, 1);
        cs_n = 1;
      end
      tick(6);
      check({tag, " no extra commit"}, we_cnt - w0, 1);
      model[a] = d;
    end else begin
      rd_n = 0;
      tick(8);
      check({tag, " oe during read"}, bus_oe, 1);
      check({tag, " read data"}, bus_dout, model[a]);
      cs_n = 1;
      tick(4);
      check("R7 oe released after cs rise", bus_oe, 0);
      rd_n = 1;
      tick(6);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0, w0;
    for (int i = 0; i < 256; i++) begin bank[i] = 0; model[i] = 0; end
    void'($urandom(32'd20240611));
    tick(3);
    // R9 reset state
    check("R9 oe", bus_oe, 0);
    check("R9 we", reg_we, 0);
    check("R9 re", reg_re, 0);
    check("R9 addr", reg_addr, 0);
    rst_n = 1;
    tick(3);

    // directed: R2/R1 split mode, R4/R3 strobe/direction mode
    bus_op(0, 8'h10, 1, 8'h3C, 0, "R2");
    bus_op(0, 8'h10, 0, 8'h00, 0, "R1");
    bus_op(1, 8'hFF, 1, 8'hC3, 0, "R4");
    bus_op(1, 8'hFF, 0, 8'h00, 0, "R3");
    bus_op(0, 8'h00, 0, 8'h00, 0, "R1");

    // R8 chip select rises before the strobe, both modes
    bus_op(0, 8'h21, 1, 8'h5A, 1, "R8");
    bus_op(0, 8'h21, 0, 8'h00, 0, "R8");
    bus_op(1, 8'h22, 1, 8'hA5, 1, "R8");
    bus_op(1, 8'h22, 0, 8'h00, 0, "R8");

    // R5 address holds while bus wiggles after the ALE fall
    latch_addr(8'h44);
    for (int k = 0; k < 6; k++) begin bus_din = 8'h80 + k[7:0]; tick(2); end
    check("R5 addr held", reg_addr, 8'h44);
    bus_op(0, 8'h45, 1, 8'h44, 0, "R5");
    bus_op(0, 8'h44, 0, 8'h00, 0, "R5");

    // R6 strobes with cs_n high in both modes
    for (int md = 0; md < 2; md++) begin
      bus_mode = md[0];
      r0 = re_cnt;
      w0 = we_cnt;
      latch_addr(8'h10);
      bus_din = 8'hEE;
      wr_n = 0; if (md == 1) rd_n = 0;
      tick(8);
      idle_strobes(); tick(4);
      rd_n = 0;
      tick(8);
      check("R6 no oe with cs high", bus_oe, 0);
      rd_n = 1; tick(4);
      check("R6 no write with cs high", we_cnt - w0, 0);
      check("R6 no read with cs high", re_cnt - r0, 0);
    end
    bus_op(0, 8'h10, 0, 8'h00, 0, "R6");

    // random mix of modes, addresses and directions
    for (int n = 0; n < 80; n++) begin
      bit md, wr, early;
      logic [7:0] a, d;
      md = 1'($urandom);
      wr = 1'($urandom);
      early = 1'($urandom);
      a = 8'($urandom);
      d = 8'($urandom);
      bus_op(md, a, wr, d, early, md ? (wr ? "R4" : "R3") : (wr ? "R2" : "R1"));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule